// File: doc/BRIEF.md
# Translation Buffer Insertion Unit

This block holds a 64-entry, fully associative table of address translations and decides where each new translation is written. A translation arrives as a tag (virtual page address plus context number) and a data word (physical page, page size and permission flags), together with a small access address that carries an entry index and two control flags. Two write paths exist. The indexed path overwrites the entry named by the access address. The insertion path picks an entry by itself.

In insertion, when hypervisor mode is on, the unit first looks for an existing entry that the new page collides with: same context, and virtual ranges that touch. That entry is overwritten, so one page never has two live translations. If there is no collision, or hypervisor mode is off, an invalid entry is used. If none is invalid, a used-bit policy picks the victim and never evicts locked entries. In hypervisor mode the data word may also come in an alternate bit layout, which is moved into the native layout before it is stored. Writes flagged as real-address translations are discarded. A combinational read port exposes any entry, and the index that was written is reported one cycle after the strobe.

Top module: `tlb_insert`

## Requirements
- R1: After reset every entry's tag and data read as zero, and `wr_done` and `ovf_err` are low.
- R2: A tag's low 13 bits are its context. Its bits [63:13], with the low 13 bits as zero, are the virtual page address. The written tag is stored unchanged.
- R3: With `hyp_en` high, an insertion overwrites the lowest-index entry that has an equal context and either an equal virtual address or an overlapping range [va, va+size). Size is 8192 << (3 × code), with the code in data bits [62:61]. The valid bit is not considered. With `hyp_en` low, no overlap search is made.
- R4: Without an overlap hit, insertion writes the lowest-index entry whose valid bit (data bit 63) is 0.
- R5: With no invalid entry, insertion writes the lowest-index entry whose locked bit (data bit 6) and used bit (data bit 41) are both 0.
- R6: If every unlocked entry has its used bit set, insertion clears the used bit of all unlocked entries and writes the lowest-index unlocked entry. The new entry keeps the used bit of its own data.
- R7: If every entry is locked, an insertion changes no entry, `wr_done` stays low, and `ovf_err` pulses for one cycle.
- R8: A write with `wr_addr[9]` (real flag) set changes no entry, on either path, and raises neither `wr_done` nor `ovf_err`.
- R9: An indexed write (`wr_indexed` high) overwrites the entry at `wr_addr[8:3]`, whatever the policy state.
- R10: With `hyp_en` high and `wr_addr[10]` (alternate flag) set, stored data is converted on both paths. Bits 63 and [40:13] are kept. Bits [1:0] go to [62:61]. The other moves are 62→60 (no-fault), 47→41 (used), 6→1 (writable), 11→3 (side effect), 8→2 (privileged) and 61→6 (locked). All other bits are 0.
- R11: With `hyp_en` low, `wr_addr[10]` has no effect and the data word is stored unchanged.
- R12: The cycle after an accepted write strobe, `wr_done` is high for one cycle, `wr_index` holds the written entry, and the read port shows the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hyp_en | input | 1 | Hypervisor mode: enables overlap eviction and the alternate data layout |
| wr_valid | input | 1 | Write strobe, one cycle per write |
| wr_indexed | input | 1 | 1 selects the indexed path, 0 the insertion path |
| wr_addr | input | 8 | Access address bits [10:3]: alternate flag, real flag, entry index |
| wr_tag | input | 64 | Virtual page address and context |
| wr_data | input | 64 | Translation data word |
| rd_idx | input | 6 | Entry selected on the read port |
| wr_done | output | 1 | One-cycle pulse after an accepted write |
| wr_index | output | 6 | Entry written by the last accepted write |
| ovf_err | output | 1 | One-cycle pulse when an insertion finds every entry locked |
| rd_tag | output | 64 | Tag of entry `rd_idx` |
| rd_data | output | 64 | Data of entry `rd_idx` |

## Verification
The assertions assume that `wr_valid` is never high in two cycles in a row, and that the control inputs are stable while a strobe is sampled. The bench drives every write for one cycle and leaves an idle cycle before the next, and it changes `hyp_en` only between writes. The overlap sweep keeps virtual addresses far from the top of the address space, so range ends never wrap. It also puts the colliding entries in a context that the zeroed entries do not share.

// File: rtl/tlb_insert.sv
module tlb_insert #(
  parameter int ENTRIES  = 64,
  parameter int CTX_W    = 13,
  parameter int REAL_BIT = 9,
  parameter int ALT_BIT  = 10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       hyp_en,
  input  logic                       wr_valid,
  input  logic                       wr_indexed,
  input  logic [ALT_BIT:3]           wr_addr,
  input  logic [63:0]                wr_tag,
  input  logic [63:0]                wr_data,
  input  logic [$clog2(ENTRIES)-1:0] rd_idx,
  output logic                       wr_done,
  output logic [$clog2(ENTRIES)-1:0] wr_index,
  output logic                       ovf_err,
  output logic [63:0]                rd_tag,
  output logic [63:0]                rd_data
);
  localparam int IDX_W  = $clog2(ENTRIES);
  localparam int VALID  = 63;
  localparam int USED   = 41;
  localparam int LOCK   = 6;
  localparam int SZ_LO  = 61;

  logic [63:0] tag_q  [ENTRIES];
  logic [63:0] data_q [ENTRIES];

  function automatic logic [63:0] to_native(input logic [63:0] a);
    logic [63:0] n;
    n          = '0;
    n[63]      = a[63];
    n[40:13]   = a[40:13];
    n[62:61]   = a[1:0];
    n[60]      = a[62];
    n[41]      = a[47];
    n[1]       = a[6];
    n[3]       = a[11];
    n[2]       = a[8];
    n[6]       = a[61];
    return n;
  endfunction

  function automatic logic [64:0] pg_bytes(input logic [1:0] code);
    return 65'd8192 << (3 * code);
  endfunction

  function automatic logic [IDX_W-1:0] lowest(input logic [ENTRIES-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (v[i]) r = IDX_W'(i);
    return r;
  endfunction

  logic [63:0] new_data;
  logic [64:0] new_va, new_sz;
  logic [ENTRIES-1:0] hit, inval, free, unlk;
  logic [IDX_W-1:0] pick;
  logic pick_ok, clr_used, ignore, accept, ovf_n;

  assign new_data = (hyp_en && wr_addr[ALT_BIT]) ? to_native(wr_data) : wr_data;
  assign new_va   = {1'b0, wr_tag[63:CTX_W], {CTX_W{1'b0}}};
  assign new_sz   = pg_bytes(new_data[SZ_LO+1:SZ_LO]);
  assign ignore   = wr_addr[REAL_BIT];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic [64:0] va_i, sz_i;
    assign va_i     = {1'b0, tag_q[i][63:CTX_W], {CTX_W{1'b0}}};
    assign sz_i     = pg_bytes(data_q[i][SZ_LO+1:SZ_LO]);
    assign hit[i]   = (tag_q[i][CTX_W-1:0] == wr_tag[CTX_W-1:0]) &&
                      (va_i == new_va || (new_va < va_i + sz_i && va_i < new_va + new_sz));
    assign inval[i] = !data_q[i][VALID];
    assign unlk[i]  = !data_q[i][LOCK];
    assign free[i]  = !data_q[i][LOCK] && !data_q[i][USED];
  end

  always_comb begin
    pick     = '0;
    pick_ok  = 1'b1;
    clr_used = 1'b0;
    if (wr_indexed)              pick = wr_addr[IDX_W+2:3];
    else if (hyp_en && |hit)     pick = lowest(hit);
    else if (|inval)             pick = lowest(inval);
    else if (|free)              pick = lowest(free);
    else if (|unlk) begin
      pick     = lowest(unlk);
      clr_used = 1'b1;
    end else                     pick_ok = 1'b0;
  end

  assign accept = wr_valid && !ignore && pick_ok;
  assign ovf_n  = wr_valid && !ignore && !pick_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        tag_q[i]  <= '0;
        data_q[i] <= '0;
      end
      wr_done  <= 1'b0;
      ovf_err  <= 1'b0;
      wr_index <= '0;
    end else begin
      wr_done <= accept;
      ovf_err <= ovf_n;
      if (accept) wr_index <= pick;
      for (int i = 0; i < ENTRIES; i++) begin
        if (accept && clr_used && unlk[i]) data_q[i][USED] <= 1'b0;
        if (accept && pick == IDX_W'(i)) begin
          tag_q[i]  <= wr_tag;
          data_q[i] <= new_data;
        end
      end
    end
  end

  assign rd_tag  = tag_q[rd_idx];
  assign rd_data = data_q[rd_idx];

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf_err && wr_done));

  // R7
  ovf_insert_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |-> $past(wr_valid && !wr_indexed));

  // R8
  real_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_addr[REAL_BIT]) |=> (!wr_done && !ovf_err));

  // R9
  indexed_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_indexed && !wr_addr[REAL_BIT]) |=>
      (wr_done && wr_index == $past(wr_addr[IDX_W+2:3])));

  // R2
  tag_stored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |-> (tag_q[wr_index] == $past(wr_tag)));

  // R12
  done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |-> $past(wr_valid));
endmodule

// File: tb/tb_tlb_insert.sv
`timescale 1ns/1ps
module tb_tlb_insert;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hyp_en = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_indexed = 1'b0;
  logic [10:3] wr_addr = '0;
  logic [63:0] wr_tag = '0, wr_data = '0;
  logic [5:0]  rd_idx = '0;
  logic        wr_done, ovf_err;
  logic [5:0]  wr_index;
  logic [63:0] rd_tag, rd_data;

  int checks = 0;
  int errors = 0;
  logic [63:0] mt [64];
  logic [63:0] md [64];

  always #2.5 clk = ~clk;

  tlb_insert dut (
    .clk(clk), .rst_n(rst_n), .hyp_en(hyp_en), .wr_valid(wr_valid),
    .wr_indexed(wr_indexed), .wr_addr(wr_addr), .wr_tag(wr_tag), .wr_data(wr_data),
    .rd_idx(rd_idx), .wr_done(wr_done), .wr_index(wr_index), .ovf_err(ovf_err),
    .rd_tag(rd_tag), .rd_data(rd_data)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] conv(input logic [63:0] a);
    logic [63:0] r;
    r = '0;
    r[63] = a[63]; r[40:13] = a[40:13]; r[62:61] = a[1:0];
    r[60] = a[62]; r[41] = a[47]; r[1] = a[6]; r[3] = a[11]; r[2] = a[8]; r[6] = a[61];
    return r;
  endfunction

  function automatic logic [64:0] bytes_of(input logic [1:0] c);
    return 65'd8192 << (3 * c);
  endfunction

  task automatic check_all(input string req);
    int bad = -1;
    for (int i = 0; i < 64; i++) begin
      rd_idx = 6'(i);
      #0.1;
      if (bad < 0 && (rd_tag !== mt[i] || rd_data !== md[i])) bad = i;
    end
    if (bad < 0) check(1'b1, req, 0, 0);
    else begin
      rd_idx = 6'(bad);
      #0.1;
      check(1'b0, req, rd_data, md[bad]);
    end
  endtask

  task automatic wr(input bit hyp, input bit idxd, input logic [10:3] addr,
                    input logic [63:0] tag, input logic [63:0] data, input string req);
    logic [63:0] nd;
    logic [64:0] nva, nsz, va;
    int pk;
    bit e_done, e_ovf, clr;
    nd = (hyp && addr[10]) ? conv(data) : data;
    pk = -1; e_done = 1'b0; e_ovf = 1'b0; clr = 1'b0;
    if (!addr[9]) begin
      if (idxd) pk = int'(addr[8:3]);
      else begin
        nva = {1'b0, tag[63:13], 13'd0};
        nsz = bytes_of(nd[62:61]);
        if (hyp)
          for (int i = 0; i < 64; i++) begin
            va = {1'b0, mt[i][63:13], 13'd0};
            if (pk < 0 && mt[i][12:0] == tag[12:0] &&
                (va == nva || (nva < va + bytes_of(md[i][62:61]) && va < nva + nsz))) pk = i;
          end
        for (int i = 0; i < 64; i++) if (pk < 0 && !md[i][63]) pk = i;
        for (int i = 0; i < 64; i++) if (pk < 0 && !md[i][6] && !md[i][41]) pk = i;
        for (int i = 0; i < 64; i++) if (pk < 0 && !md[i][6]) begin pk = i; clr = 1'b1; end
      end
      if (pk < 0) e_ovf = 1'b1;
      else begin
        e_done = 1'b1;
        if (clr) for (int i = 0; i < 64; i++) if (!md[i][6]) md[i][41] = 1'b0;
        mt[pk] = tag;
        md[pk] = nd;
      end
    end
    @(negedge clk);
    hyp_en = hyp; wr_indexed = idxd; wr_addr = addr; wr_tag = tag; wr_data = data;
    wr_valid = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0;
    check(wr_done == e_done, {req, " R12 done"}, 64'(wr_done), 64'(e_done));
    check(ovf_err == e_ovf, {req, " R7 ovf"}, 64'(ovf_err), 64'(e_ovf));
    if (e_done) begin
      check(int'(wr_index) == pk, {req, " index"}, 64'(wr_index), 64'(pk));
      rd_idx = 6'(pk);
      #0.1;
      check(rd_tag === tag && rd_data === nd, {req, " R2 stored"}, rd_data, nd);
    end
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin mt[i] = '0; md[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!wr_done && !ovf_err, "R1 outputs", 64'({wr_done, ovf_err}), 0);
    check_all("R1 entries");

    // R4: fill from empty, lowest invalid first
    for (int i = 0; i < 64; i++)
      wr(1'b0, 1'b0, 8'h00, (64'(i) << 20) | 64'(i + 1),
         (64'd1 << 63) | (64'(i % 3 == 0) << 6) | (64'(i % 2 == 0) << 41) | (64'(i) << 13), "R4 fill");
    check_all("R4 table");

    // R5 and R6: victim choice with used and locked bits
    for (int j = 0; j < 40; j++)
      wr(1'b0, 1'b0, 8'h00, (64'(100 + j) << 20) | 64'd3,
         (64'd1 << 63) | (64'd1 << 41) | (64'(j) << 13), "R5 R6 victim");
    check_all("R6 table");

    // R9 and R11: indexed sweep, alt flag with hyp off, all entries locked
    for (int i = 0; i < 64; i++)
      wr(1'b0, 1'b1, {1'b1, 1'b0, 6'(i)}, (64'(i + 300) << 20) | 64'd5,
         (64'd1 << 63) | (64'd1 << 6) | (64'd1 << 47) | 64'd2, "R9 R11 indexed");
    check_all("R11 raw data");
    wr(1'b0, 1'b0, 8'h00, 64'h7000_0001, 64'h8000_0000_0000_0000, "R7 full");
    wr(1'b1, 1'b0, 8'h00, 64'h7100_0001, 64'h8000_0000_0000_0000, "R7 full hyp");
    check_all("R7 unchanged");

    // R8: real flag on both paths
    wr(1'b0, 1'b1, {2'b01, 6'd7}, 64'hdead_0001, 64'h1, "R8 indexed");
    wr(1'b1, 1'b0, 8'b01000000, (64'd300 << 20) | 64'd5, 64'h8000_0000_0000_0000, "R8 insert");
    check_all("R8 unchanged");

    // R3: overlap sweep
    for (int h = 0; h < 2; h++)
      for (int cx = 0; cx < 2; cx++)
        for (int c = 0; c < 4; c++)
          for (int nc = 0; nc < 4; nc++)
            for (int o = 0; o < 4; o++) begin
              logic [63:0] base, nva;
              logic [64:0] sz;
              base = 64'h0100_0000;
              sz = bytes_of(2'(c));
              case (o)
                0: nva = base - 64'd8192;
                1: nva = base;
                2: nva = base + 64'(sz) - 64'd8192;
                default: nva = base + 64'(sz);
              endcase
              for (int i = 0; i < 64; i++) wr(1'b0, 1'b1, {2'b00, 6'(i)}, 64'd0, 64'd0, "R3 clear");
              wr(1'b0, 1'b1, {2'b00, 6'd50}, base | 64'd7, (64'd1 << 63) | (64'(c) << 61), "R3 setup");
              wr(1'b0, 1'b1, {2'b00, 6'd20}, base | 64'd7, (64'd1 << 63) | (64'(c) << 61), "R3 setup");
              wr(1'b0, 1'b1, {2'b00, 6'd35}, 64'h0800_0007, 64'd1 << 63, "R3 setup");
              wr(h[0], 1'b0, 8'h00, nva | (cx ? 64'd9 : 64'd7),
                 (64'd1 << 63) | (64'(nc) << 61) | (64'h55 << 13), "R3 overlap");
              check_all("R3 table");
            end

    // R10: single-bit conversion sweep on both paths
    for (int b = 0; b < 64; b++)
      wr(1'b1, 1'b1, {2'b10, 6'(b)}, (64'(b + 1) << 24) | 64'd11, 64'd1 << b, "R10 indexed");
    for (int b = 0; b < 8; b++)
      wr(1'b1, 1'b0, 8'b10000000, (64'(b + 900) << 24) | 64'd12,
         (64'd1 << 63) | (64'd1 << 62) | (64'd1 << 47) | (64'd1 << 11) | 64'(b % 4), "R10 insert");
    check_all("R10 table");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog R12: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule